// File: doc/BRIEF.md
# Lifting Step Context Store

Each processing element of a lifting-based wavelet engine needs its current lifting step described by two multiplier constants and a handful of selector settings. This block keeps several complete step descriptions, called contexts, inside one element and drives the chosen one onto a set of registered configuration outputs. A single context index, shared by every element, selects the entry. Switching the whole engine to another filter, or to its inverse, is then a one-cycle change of that index.

Every element is loaded over a broadcast bus that all elements share. The bus carries a row ID, a context address, two constants on the data lanes and a control word on a separate lane, qualified by a write strobe. Each instance has a fixed row ID as a parameter. It compares the bus ID with that row ID and stores the write only on a match, so one bus loads every element. The configuration outputs reload only while the element reports itself idle, so a lifting step that is in flight never sees its settings move.

Top module: `lift_ctx_store`

## Requirements
- R1: After a synchronous active-low reset every configuration output is zero, and every context entry reads back as zero.
- R2: A write (`cfg_wr` high, `cfg_row` equal to the row ID) stores `cfg_k1`, `cfg_k2` and `cfg_ctl` into the entry at `cfg_ctx`. If that entry stays selected and the element stays idle on the next edge, the outputs show the written values one edge after the write edge.
- R3: A write whose `cfg_row` differs from the row ID changes no entry, and the outputs do not change.
- R4: On each clock edge with `pe_idle` high, the outputs load the entry addressed by `ctx_sel`. This is a one-cycle registered path.
- R5: While `pe_idle` is low the outputs hold their value, whatever happens to `ctx_sel` or on the bus.
- R6: An entry that was never written reads as all zero. The apply flag is then 0, which means bypass.
- R7: Control word fields: `cfg_ctl[2:0]` is tap A, `[5:3]` is tap B, bit 6 is future-sample select, bit 7 is apply (1 runs the lifting step, 0 bypasses) and bit 8 is normalization enable.
- R8: If a write and a read of the same entry happen on one edge, the outputs show the old contents on that edge and the new contents on the next idle edge.
- R9: Entries are independent: a write to one context leaves every other context unchanged, including the lowest (0) and highest (15) addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Broadcast write strobe |
| cfg_row | input | ID_W (3) | Target row ID on the bus |
| cfg_ctx | input | CTX_W (4) | Context address of the write |
| cfg_k1 | input | DATA_W (16) | First multiplier constant (data lane) |
| cfg_k2 | input | DATA_W (16) | Second multiplier constant (data lane) |
| cfg_ctl | input | 2*TAP_W+3 (9) | Control word, fields as in R7 |
| ctx_sel | input | CTX_W (4) | Global active-context index |
| pe_idle | input | 1 | Element idle; outputs may reload only when high |
| act_k1 | output | DATA_W (16) | Active first constant |
| act_k2 | output | DATA_W (16) | Active second constant |
| act_tap_a | output | TAP_W (3) | Active tap A select |
| act_tap_b | output | TAP_W (3) | Active tap B select |
| act_fut | output | 1 | Active future-sample select |
| act_apply | output | 1 | Active apply flag (0 = bypass) |
| act_norm | output | 1 | Active normalization enable |

## Verification
A sweep of all context indices straight after reset shows whether any entry starts as non-zero. Directed writes with the matching row ID and with every foreign row ID to the selected entry show whether the ID comparator alone gates storage. Writes made while the element is busy, and writes that coincide with a read of the same entry, show whether the outputs obey the idle gate and the read-before-write order. Walking single bits through the control word, and a long random mix of IDs, addresses, idle states and selections checked against a bench model, show whether fields are misplaced and whether one context leaks into another.

// File: rtl/lift_ctx_pkg.sv
package lift_ctx_pkg;

   // control word layout: {norm, apply, fut, tap_b, tap_a}
   function automatic int ctl_width(input int tap_w);
      return 2 * tap_w + 3;
   endfunction

   function automatic int off_fut(input int tap_w);
      return 2 * tap_w;
   endfunction

   function automatic int off_apply(input int tap_w);
      return 2 * tap_w + 1;
   endfunction

   function automatic int off_norm(input int tap_w);
      return 2 * tap_w + 2;
   endfunction

   // stored entry: {k2, k1, ctl}
   function automatic int entry_width(input int data_w, input int tap_w);
      return 2 * data_w + ctl_width(tap_w);
   endfunction

endpackage

// File: rtl/lift_ctx_idmatch.sv
module lift_ctx_idmatch #(
   parameter int ID_W    = 3,
   parameter int ROW_ID  = 0,
   parameter int NUM_CTX = 16,
   parameter int CTX_W   = $clog2(NUM_CTX)
) (
   input  logic               wr,
   input  logic [ID_W-1:0]    row,
   input  logic [CTX_W-1:0]   ctx,
   output logic [NUM_CTX-1:0] hit
);
   localparam logic [ID_W-1:0] MY_ROW = ID_W'(ROW_ID);
   localparam bit POW2 = ((1 << CTX_W) == NUM_CTX);

   logic row_ok;
   logic ctx_ok;

   assign row_ok = wr && (row == MY_ROW);

   generate
      if (POW2) begin : g_full_range
         assign ctx_ok = 1'b1;
      end else begin : g_range_check
         assign ctx_ok = (int'(ctx) < NUM_CTX);
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_CTX; i++) begin : g_dec
         assign hit[i] = row_ok && ctx_ok && (ctx == CTX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/lift_ctx_bank.sv
module lift_ctx_bank #(
   parameter int ENT_W   = 41,
   parameter int NUM_CTX = 16,
   parameter int CTX_W   = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CTX-1:0] hit,
   input  logic [ENT_W-1:0]   wdata,
   input  logic [CTX_W-1:0]   rsel,
   output logic [ENT_W-1:0]   rdata
);
   logic [ENT_W-1:0] ent [NUM_CTX];

   generate
      for (genvar i = 0; i < NUM_CTX; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent[i] <= '0;
            end else if (hit[i]) begin
               ent[i] <= wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CTX; i++) begin
         if (rsel == CTX_W'(i)) rdata = ent[i];
      end
   end
endmodule

// File: rtl/lift_ctx_outreg.sv
module lift_ctx_outreg
   import lift_ctx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int TAP_W  = 3,
   parameter int ENT_W  = entry_width(DATA_W, TAP_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ENT_W-1:0]  ent_in,
   output logic [DATA_W-1:0] k1,
   output logic [DATA_W-1:0] k2,
   output logic [TAP_W-1:0]  tap_a,
   output logic [TAP_W-1:0]  tap_b,
   output logic              fut,
   output logic              apply,
   output logic              norm
);
   localparam int CW     = ctl_width(TAP_W);
   localparam int O_FUT  = off_fut(TAP_W);
   localparam int O_APP  = off_apply(TAP_W);
   localparam int O_NORM = off_norm(TAP_W);

   logic [ENT_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (load) begin
         hold_q <= ent_in;
      end
   end

   assign tap_a = hold_q[TAP_W-1:0];
   assign tap_b = hold_q[2*TAP_W-1:TAP_W];
   assign fut   = hold_q[O_FUT];
   assign apply = hold_q[O_APP];
   assign norm  = hold_q[O_NORM];
   assign k1    = hold_q[CW +: DATA_W];
   assign k2    = hold_q[CW+DATA_W +: DATA_W];
endmodule

// File: rtl/lift_ctx_store.sv
module lift_ctx_store
   import lift_ctx_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int TAP_W   = 3,
   parameter int NUM_CTX = 16,
   parameter int ID_W    = 3,
   parameter int ROW_ID  = 5,
   parameter int CTX_W   = $clog2(NUM_CTX),
   parameter int CTL_W   = ctl_width(TAP_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ID_W-1:0]   cfg_row,
   input  logic [CTX_W-1:0]  cfg_ctx,
   input  logic [DATA_W-1:0] cfg_k1,
   input  logic [DATA_W-1:0] cfg_k2,
   input  logic [CTL_W-1:0]  cfg_ctl,
   input  logic [CTX_W-1:0]  ctx_sel,
   input  logic              pe_idle,
   output logic [DATA_W-1:0] act_k1,
   output logic [DATA_W-1:0] act_k2,
   output logic [TAP_W-1:0]  act_tap_a,
   output logic [TAP_W-1:0]  act_tap_b,
   output logic              act_fut,
   output logic              act_apply,
   output logic              act_norm
);
   localparam int ENT_W = entry_width(DATA_W, TAP_W);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("lift_ctx_store: DATA_W must be at least 2");
      end
      if (TAP_W < 1) begin : g_bad_tap_w
         $error("lift_ctx_store: TAP_W must be at least 1");
      end
      if (NUM_CTX < 2 || NUM_CTX > (1 << CTX_W)) begin : g_bad_ctx
         $error("lift_ctx_store: NUM_CTX out of range for CTX_W");
      end
      if (ID_W < 1 || ROW_ID < 0 || ROW_ID >= (1 << ID_W)) begin : g_bad_row
         $error("lift_ctx_store: ROW_ID does not fit in ID_W");
      end
      if (CTL_W != ctl_width(TAP_W)) begin : g_bad_ctl
         $error("lift_ctx_store: CTL_W must not be overridden");
      end
   endgenerate

   logic [NUM_CTX-1:0] wr_hit;
   logic [ENT_W-1:0]   wr_ent;
   logic [ENT_W-1:0]   rd_ent;

   assign wr_ent = {cfg_k2, cfg_k1, cfg_ctl};

   lift_ctx_idmatch #(
      .ID_W    (ID_W),
      .ROW_ID  (ROW_ID),
      .NUM_CTX (NUM_CTX),
      .CTX_W   (CTX_W)
   ) u_match (
      .wr  (cfg_wr),
      .row (cfg_row),
      .ctx (cfg_ctx),
      .hit (wr_hit)
   );

   lift_ctx_bank #(
      .ENT_W   (ENT_W),
      .NUM_CTX (NUM_CTX),
      .CTX_W   (CTX_W)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (wr_hit),
      .wdata (wr_ent),
      .rsel  (ctx_sel),
      .rdata (rd_ent)
   );

   lift_ctx_outreg #(
      .DATA_W (DATA_W),
      .TAP_W  (TAP_W),
      .ENT_W  (ENT_W)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (pe_idle),
      .ent_in (rd_ent),
      .k1     (act_k1),
      .k2     (act_k2),
      .tap_a  (act_tap_a),
      .tap_b  (act_tap_b),
      .fut    (act_fut),
      .apply  (act_apply),
      .norm   (act_norm)
   );
endmodule

// File: rtl/lift_ctx_store_chk.sv
module lift_ctx_store_chk #(
   parameter int DATA_W = 16,
   parameter int TAP_W  = 3,
   parameter int ID_W   = 3,
   parameter int ROW_ID = 5,
   parameter int CTX_W  = 4,
   parameter int CTL_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [ID_W-1:0]   cfg_row,
   input logic [CTX_W-1:0]  cfg_ctx,
   input logic [DATA_W-1:0] cfg_k1,
   input logic [DATA_W-1:0] cfg_k2,
   input logic [CTL_W-1:0]  cfg_ctl,
   input logic [CTX_W-1:0]  ctx_sel,
   input logic              pe_idle,
   input logic [DATA_W-1:0] act_k1,
   input logic [DATA_W-1:0] act_k2,
   input logic [TAP_W-1:0]  act_tap_a,
   input logic [TAP_W-1:0]  act_tap_b,
   input logic              act_fut,
   input logic              act_apply,
   input logic              act_norm
);
   localparam logic [ID_W-1:0] MY_ROW = ID_W'(ROW_ID);

   logic [2*DATA_W+CTL_W-1:0] act_all;
   logic                      own_wr;

   assign act_all = {act_k2, act_k1, act_norm, act_apply, act_fut, act_tap_b, act_tap_a};
   assign own_wr  = cfg_wr && (cfg_row == MY_ROW);

   // R1: reset clears the outputs
   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (act_all == '0));

   // R5: busy element holds its configuration
   p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pe_idle |=> $stable(act_all));

   // R3: no own write and unchanged selection gives unchanged outputs
   p_foreign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_idle && $past(pe_idle) && $stable(ctx_sel) && !$past(own_wr))
      |=> $stable(act_all));

   // R2: own write to the selected entry appears one edge later
   p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wr && (cfg_ctx == ctx_sel)) ##1 (pe_idle && $stable(ctx_sel))
      |=> (act_all == $past({cfg_k2, cfg_k1, cfg_ctl}, 2)));
endmodule

bind lift_ctx_store lift_ctx_store_chk #(
   .DATA_W (DATA_W),
   .TAP_W  (TAP_W),
   .ID_W   (ID_W),
   .ROW_ID (ROW_ID),
   .CTX_W  (CTX_W),
   .CTL_W  (CTL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_row   (cfg_row),
   .cfg_ctx   (cfg_ctx),
   .cfg_k1    (cfg_k1),
   .cfg_k2    (cfg_k2),
   .cfg_ctl   (cfg_ctl),
   .ctx_sel   (ctx_sel),
   .pe_idle   (pe_idle),
   .act_k1    (act_k1),
   .act_k2    (act_k2),
   .act_tap_a (act_tap_a),
   .act_tap_b (act_tap_b),
   .act_fut   (act_fut),
   .act_apply (act_apply),
   .act_norm  (act_norm)
);

// File: tb/lift_ctx_store_tb.sv
`timescale 1ns/1ps
module lift_ctx_store_tb;
   localparam int MY_ROW = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_row = '0;
   logic [3:0]  cfg_ctx = '0;
   logic [15:0] cfg_k1 = '0;
   logic [15:0] cfg_k2 = '0;
   logic [8:0]  cfg_ctl = '0;
   logic [3:0]  ctx_sel = '0;
   logic        pe_idle = 1'b0;
   logic [15:0] act_k1, act_k2;
   logic [2:0]  act_tap_a, act_tap_b;
   logic        act_fut, act_apply, act_norm;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model: {k2, k1, ctl} per context
   logic [40:0] model [16];
   logic [40:0] exp_ent;

   always #2.5 clk = ~clk;

   lift_ctx_store u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_row(cfg_row),
      .cfg_ctx(cfg_ctx), .cfg_k1(cfg_k1), .cfg_k2(cfg_k2), .cfg_ctl(cfg_ctl),
      .ctx_sel(ctx_sel), .pe_idle(pe_idle), .act_k1(act_k1), .act_k2(act_k2),
      .act_tap_a(act_tap_a), .act_tap_b(act_tap_b), .act_fut(act_fut),
      .act_apply(act_apply), .act_norm(act_norm)
   );

   // expected output view of an entry, fields per R7
   function automatic logic [40:0] view(input logic [40:0] e);
      logic [8:0] c;
      c = e[8:0];
      return {e[40:25], e[24:9], c[8], c[7], c[6], c[5:3], c[2:0]};
   endfunction

   function automatic logic [8:0] mk_ctl(input logic [2:0] ta, input logic [2:0] tb,
                                         input logic f, input logic ap, input logic nm);
      return {nm, ap, f, tb, ta};
   endfunction

   task automatic compare(input string tag);
      logic [40:0] act;
      logic [40:0] expv;
      act  = {act_k2, act_k1, act_norm, act_apply, act_fut, act_tap_b, act_tap_a};
      expv = view(exp_ent);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // one cycle: drive at negedge, model the edge, check at next negedge
   task automatic cyc(input logic wr, input logic [2:0] row, input logic [3:0] ctx,
                      input logic [15:0] k1, input logic [15:0] k2, input logic [8:0] ctl,
                      input logic [3:0] sel, input logic idl, input string tag);
      cfg_wr = wr; cfg_row = row; cfg_ctx = ctx;
      cfg_k1 = k1; cfg_k2 = k2; cfg_ctl = ctl;
      ctx_sel = sel; pe_idle = idl;
      if (idl) exp_ent = model[sel];
      if (wr && row == 3'(MY_ROW)) model[ctx] = {k2, k1, ctl};
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic nop(input logic [3:0] sel, input logic idl, input string tag);
      cyc(1'b0, 3'(MY_ROW), 4'd0, 16'h0, 16'h0, 9'h0, sel, idl, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_wr = 1'b0; pe_idle = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 16; i++) model[i] = '0;
      exp_ent = '0;
      rst_n = 1'b1;
      compare("R1 reset");
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      do_reset();

      // R1 / R6: every entry reads zero after reset (apply = 0, bypass)
      for (int s = 0; s < 16; s++) nop(4'(s), 1'b1, "R6 unwritten zero");

      // R8: write and read the same entry on one edge, then R2 visible
      cyc(1'b1, 3'(MY_ROW), 4'd3, 16'hA5C3, 16'h1F0E, mk_ctl(3'd2, 3'd5, 1'b1, 1'b1, 1'b0),
          4'd3, 1'b1, "R8 old on same edge");
      nop(4'd3, 1'b1, "R2 new after write");

      // R3: every foreign row ID to the selected entry
      for (int r = 0; r < 8; r++) begin
         if (r != MY_ROW)
            cyc(1'b1, 3'(r), 4'd3, 16'hFFFF, 16'hFFFF, 9'h1FF, 4'd3, 1'b1, "R3 foreign write");
      end
      nop(4'd3, 1'b1, "R3 entry unchanged");

      // R5: busy element ignores writes and selection changes
      cyc(1'b1, 3'(MY_ROW), 4'd7, 16'h0042, 16'h8001, mk_ctl(3'd7, 3'd0, 1'b0, 1'b1, 1'b1),
          4'd7, 1'b0, "R5 hold on write");
      nop(4'd0, 1'b0, "R5 hold on select");
      nop(4'd7, 1'b0, "R5 hold");
      nop(4'd7, 1'b1, "R4 load when idle");

      // R7: walk a single bit through the control word
      for (int b = 0; b < 9; b++) begin
         cyc(1'b1, 3'(MY_ROW), 4'd9, 16'(b), 16'(~b), 9'(1 << b), 4'd9, 1'b1, "R7 write field");
         nop(4'd9, 1'b1, "R7 field position");
      end

      // R9: extreme addresses stay independent
      cyc(1'b1, 3'(MY_ROW), 4'd15, 16'h7777, 16'h8888, mk_ctl(3'd1, 3'd6, 1'b0, 1'b1, 1'b1),
          4'd0, 1'b1, "R9 write top");
      cyc(1'b1, 3'(MY_ROW), 4'd0, 16'h1111, 16'h2222, mk_ctl(3'd4, 3'd3, 1'b1, 1'b0, 1'b0),
          4'd15, 1'b1, "R9 write bottom");
      nop(4'd15, 1'b1, "R9 top kept");
      nop(4'd0, 1'b1, "R9 bottom kept");
      nop(4'd3, 1'b1, "R9 other kept");

      // R4: random mix against the model
      for (int n = 0; n < 600; n++) begin
         logic [2:0] row;
         row = ($urandom % 2) ? 3'(MY_ROW) : 3'($urandom);
         cyc(1'($urandom % 3 == 0), row, 4'($urandom), 16'($urandom), 16'($urandom),
             9'($urandom), 4'($urandom), 1'($urandom % 4 != 0), "R4 random");
      end

      // R1: reset in mid-run clears the outputs and all entries
      do_reset();
      for (int s = 0; s < 16; s++) nop(4'(s), 1'b1, "R1 entries cleared");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule